// File: doc/BRIEF.md
# GPIO Port Controller with Set/Clear and Dual Direction Views

This block is a general-purpose I/O port that software reaches through a small register bus (word address, write strobe, write data, read strobe, read data). One register bit stands for each line. The number of lines equals the register width, which is chosen at build time. The block keeps an output latch and a single direction vector. It drives the latch and the direction onto the pad-side output and output-enable vectors. It samples the pad inputs through a synchroniser.

Output values can be loaded whole through the data register, or changed bit by bit through write-one-to-set and write-one-to-clear registers. These two registers let software change some lines without a read-modify-write. Direction can be written and read either as an output-enable view or as its complement, an input-enable view. Both views share one state, so a line is never both input and output. A build option reverses the bit numbering, so that line 0 sits at the most significant register bit.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Parameter `W` is restricted to 8, 16, 32 or 64. The port has exactly `W` lines, and each register is `W` bits wide.
- R2: After reset, `pin_oe_o` is all zeros (all lines inputs), `pin_o` is all zeros and `rd_data_o` is zero.
- R3: A write to the data register (address 0) loads the output latch with the written value. The latch drives `pin_o` whatever the direction. Reading the set register (address 1) returns the latch and not the pad level.
- R4: A write to the set register (address 1) drives high every line whose written bit is 1. Lines written with 0 keep their latch value.
- R5: A write to the clear register (address 2) drives low every line whose written bit is 1. Lines written with 0 keep their latch value. Reading address 2 returns zero.
- R6: A write to the output-direction register (address 3) loads the direction, where 1 means output. `pin_oe_o` follows on the next cycle, and reading address 3 returns the direction.
- R7: A write to the input-direction register (address 4) loads the complement of the written value into the direction, where 1 means input. Reading address 4 always returns the bitwise complement of address 3.
- R8: Reading the data register returns, for each line, the latch bit when the line is an output and the synchronised pad bit when it is an input.
- R9: Pad inputs pass through two flops. A pad change made before clock edge k is first returned by a read strobe sampled at edge k+2.
- R10: Read data appears on `rd_data_o` in the cycle after the edge that samples `rd_en_i`. In a cycle after an edge with `rd_en_i` low, `rd_data_o` is zero.
- R11: With `MIRROR` set, line n corresponds to register bit W-1-n in every register, for both reads and writes. `pin_o`, `pin_oe_o` and `pin_i` stay in line order.
- R12: Writes to addresses 5 to 7 change no state, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | W | Write data, register bit order |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | W | Read data, valid one cycle after the strobe |
| pin_i | input | W | Pad input levels, line order |
| pin_o | output | W | Output latch, line order |
| pin_oe_o | output | W | Output enables, line order |

## Verification
A corrupted output latch shows on `pin_o` on the cycle after the write that caused it. It also shows on the next read of the set register. A wrong direction state shows at once on `pin_oe_o`, and in the complement between the two direction reads. Each data-register read then returns a mix of latch and pad bits that differs from the expected one. Mirroring faults show as a reversed word on the first read or write of the mirrored copy. Synchroniser faults show as an early or late pad value in a read issued zero, one or two cycles after the pad change.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 3'd0,
    REG_SET     = 3'd1,
    REG_CLR     = 3'd2,
    REG_DIR_OUT = 3'd3,
    REG_DIR_IN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_bit_order.sv
// Maps between register bit order and line order; self-inverse.
module gpio_bit_order #(
  parameter int W      = 32,
  parameter bit MIRROR = 1'b0
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  if (MIRROR) begin : g_mirror
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign out_o[i] = in_i[W-1-i];
    end
  end else begin : g_direct
    assign out_o = in_i;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
// Output latch and direction state, line order.
module gpio_out_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wd_line_i,
  output logic [W-1:0]      latch_o,
  output logic [W-1:0]      dir_o
);
  logic [W-1:0] latch_d, dir_d;

  always_comb begin
    latch_d = latch_o;
    dir_d   = dir_o;
    if (wr_en_i) begin
      case (addr_i)
        REG_DATA:    latch_d = wd_line_i;
        REG_SET:     latch_d = latch_o | wd_line_i;
        REG_CLR:     latch_d = latch_o & ~wd_line_i;
        REG_DIR_OUT: dir_d   = wd_line_i;
        REG_DIR_IN:  dir_d   = ~wd_line_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
    end else begin
      latch_o <= latch_d;
      dir_o   <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W      = 32,   // 8, 16, 32 or 64
  parameter bit MIRROR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              rd_en_i,
  output logic [W-1:0]      rd_data_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o
);
  logic [W-1:0] wd_line, latch, dir, pin_sync, level, rd_line, rd_bus;

  gpio_bit_order #(.W(W), .MIRROR(MIRROR)) u_wr_order (
    .in_i (wr_data_i),
    .out_o(wd_line)
  );

  gpio_out_regs #(.W(W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wd_line_i(wd_line),
    .latch_o  (latch),
    .dir_o    (dir)
  );

  gpio_in_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign level = (latch & dir) | (pin_sync & ~dir);

  always_comb begin
    case (addr_i)
      REG_DATA:    rd_line = level;
      REG_SET:     rd_line = latch;
      REG_DIR_OUT: rd_line = dir;
      REG_DIR_IN:  rd_line = ~dir;
      default:     rd_line = '0;
    endcase
  end

  gpio_bit_order #(.W(W), .MIRROR(MIRROR)) u_rd_order (
    .in_i (rd_line),
    .out_o(rd_bus)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else rd_data_o <= rd_en_i ? rd_bus : '0;
  end

  assign pin_o    = latch;
  assign pin_oe_o = dir;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int W      = 32,
  parameter bit MIRROR = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   addr_i,
  input logic         wr_en_i,
  input logic [W-1:0] wr_data_i,
  input logic         rd_en_i,
  input logic [W-1:0] rd_data_o,
  input logic [W-1:0] pin_o,
  input logic [W-1:0] pin_oe_o
);
  logic [W-1:0] wl;
  for (genvar i = 0; i < W; i++) begin : g_map
    assign wl[i] = MIRROR ? wr_data_i[W-1-i] : wr_data_i[i];
  end

  // R3
  a_r3_data_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0) |=> pin_o == $past(wl));
  // R4
  a_r4_set_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd1) |=> (pin_o & $past(wl)) == $past(wl));
  a_r4_set_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd1) |=> (pin_o & ~$past(wl)) == ($past(pin_o) & ~$past(wl)));
  // R5
  a_r5_clr_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd2) |=> (pin_o & $past(wl)) == '0);
  a_r5_clr_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd2) |=> (pin_o & ~$past(wl)) == ($past(pin_o) & ~$past(wl)));
  // R6
  a_r6_dir_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd3) |=> pin_oe_o == $past(wl));
  a_r6_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (addr_i == 3'd3 || addr_i == 3'd4)) |=> $stable(pin_oe_o));
  // R7
  a_r7_dir_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd4) |=> pin_oe_o == ~$past(wl));
  // R10
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rd_data_o == '0);
  // R12
  a_r12_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > 3'd4) |=> $stable(pin_o) && $stable(pin_oe_o));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.W(W), .MIRROR(MIRROR)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/gpio_port_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_port_ctrl_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         we = 1'b0, re = 1'b0;
  logic [W-1:0] wd = '0, pin = '0;
  logic [W-1:0] rd0, po0, oe0, rd1, po1, oe1, wd_m;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    for (int i = 0; i < W; i++) rev[i] = v[W-1-i];
  endfunction

  assign wd_m = rev(wd);

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.W(W), .MIRROR(1'b0)) u_gpio_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
    .rd_en_i(re), .rd_data_o(rd0), .pin_i(pin), .pin_o(po0), .pin_oe_o(oe0));

  gpio_port_ctrl #(.W(W), .MIRROR(1'b1)) u_gpio_port_ctrl_mir (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd_m),
    .rd_en_i(re), .rd_data_o(rd1), .pin_i(pin), .pin_o(po1), .pin_oe_o(oe1));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Both copies see the same line-order state; mirror copy gets reversed bus data.
  task automatic wr(input logic [2:0] a, input logic [W-1:0] v);
    @(negedge clk); addr = a; wd = v; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] exp, input string req);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
    chk(req, rd0, exp);
    chk({req, " R11 mirrored"}, rd1, rev(exp));
  endtask

  task automatic pins(input logic [W-1:0] l, input logic [W-1:0] d, input string req);
    chk(req, po0, l);
    chk({req, " R11 mirrored"}, po1, l);
    chk(req, oe0, d);
    chk({req, " R11 mirrored"}, oe1, d);
  endtask

  initial begin
    logic [W-1:0] lat, dir, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    pins('0, '0, "R2 reset");
    chk("R2 reset rd", rd0, '0);
    rd(3'd3, '0, "R2 dir_out after reset");
    rd(3'd4, '1, "R7 dir_in after reset");

    // R1 R3: data load, latch stored while inputs, set reg reads latch
    for (int v = 0; v < 256; v++) begin
      lat = W'(v);
      wr(3'd0, lat);
      pins(lat, '0, "R3 R1 data load");
      rd(3'd1, lat, "R3 set readback");
    end

    // R4 set, R5 clear
    for (int a = 0; a < 256; a++) begin
      b = W'(a) ^ 8'hA5;
      wr(3'd0, b);
      wr(3'd1, W'(a));
      pins(b | W'(a), '0, "R4 set");
      wr(3'd2, W'(a * 37));
      pins((b | W'(a)) & ~W'(a * 37), '0, "R5 clear");
    end
    rd(3'd2, '0, "R5 clr reads zero");

    // R6 R7 direction views
    for (int d = 0; d < 256; d++) begin
      dir = W'(d);
      if (d % 2 == 0) wr(3'd3, dir);
      else wr(3'd4, ~dir);
      chk("R6 R7 pin_oe", oe0, dir);
      chk("R6 R7 pin_oe R11 mirrored", oe1, dir);
      rd(3'd3, dir, "R6 dir_out read");
      rd(3'd4, ~dir, "R7 dir_in read");
    end

    // R8 data level mix
    lat = 8'hA6; dir = 8'h3C;
    wr(3'd0, lat);
    wr(3'd3, dir);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); pin = W'(p);
      repeat (2) @(negedge clk);
      rd(3'd0, (lat & dir) | (W'(p) & ~dir), "R8 data level");
    end

    // R9 sync latency and R10 read timing
    wr(3'd3, '0);
    @(negedge clk); pin = '0;
    repeat (3) @(negedge clk);
    addr = 3'd0; pin = 8'hFF; re = 1'b1;
    @(negedge clk); chk("R9 R10 edge k", rd0, 8'h00);
    @(negedge clk); chk("R9 edge k+1", rd0, 8'h00);
    @(negedge clk); chk("R9 edge k+2", rd0, 8'hFF);
    chk("R9 edge k+2 R11 mirrored", rd1, 8'hFF);
    re = 1'b0;
    @(negedge clk); chk("R10 idle zero", rd0, '0);

    // R12 unmapped addresses
    wr(3'd0, 8'h5A);
    wr(3'd3, 8'hC3);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      pins(8'h5A, 8'hC3, "R12 unmapped write");
      rd(3'(a), '0, "R12 unmapped read");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule